// File: doc/BRIEF.md
# Split-EOI CPU Interrupt Interface

This block sits between a set of interrupt request lines and one processor core. It records which interrupts are pending and which are active, holds a programmable priority for each, and raises `irq_out` while at least one interrupt may be taken. The core claims that interrupt with an acknowledge read, which returns its ID and makes its priority the running priority. Software then ends the interrupt through register writes.

Ending an interrupt has two steps: a priority drop and a deactivation. A mode bit in the control register decides whether an end-of-interrupt write does both steps or only the drop. When it only drops the priority, the interrupt stays active until a separate deactivate write names it. Other interrupts at the same level can then be taken, but the dropped interrupt cannot be signalled again until it has been deactivated.

Running priorities are kept on a small stack, one entry for each acknowledged interrupt that has not yet been dropped. A numerically lower priority value is more urgent. The all-ones value stands for "idle".

Top module: `cpuif_split_eoi`

## Requirements
- R1: After reset `irq_out` is 0, `run_prio` is all ones, the priority mask and control register read as 0, and an acknowledge read returns 1023.
- R2: No interrupt is signalled or acknowledged while the group-enable bit (control bit 1, register select 4) is 0.
- R3: An interrupt is eligible only if all of the following hold: it is pending, it is not active, its priority value is strictly below the mask (register select 3, low PRIO_W bits), and its priority value is strictly below `run_prio`. `irq_out` is 1 exactly when some interrupt is eligible.
- R4: A read with select 0 returns the ID of the eligible interrupt with the lowest priority value; among equal values the lowest ID wins. That interrupt moves from pending to active, and its priority becomes `run_prio` in the next cycle.
- R5: When nothing is eligible, an acknowledge read returns 1023 and changes no state.
- R6: `run_prio` is the priority at the top of the stack, or all ones when the stack is empty. An interrupt at the same level as `run_prio` does not preempt it.
- R7: With control bit 0 (split mode) clear, an end-of-interrupt write (select 1, data = ID) pops one stack entry, if there is one, and clears the active state of the named interrupt.
- R8: With split mode set, an end-of-interrupt write pops the stack only. The named interrupt stays active and is not signalled again, while other interrupts at the freed level can be taken.
- R9: In split mode, a deactivate write (select 2, data = ID) clears the active state of the named interrupt, so it can be acknowledged again.
- R10: A deactivate write has no effect when split mode is clear, or when the named interrupt is not active.
- R11: End-of-interrupt and deactivate writes naming an ID that is not implemented have no effect. This covers IDs at or above NUM_IRQ, the invalid range 1020–8191, and IDs of 8192 and above.
- R12: While the stack holds STACK_DEPTH entries, nothing is signalled and acknowledge reads return 1023 until a drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_IRQ | One-cycle pulses that set the pending state, one bit per ID |
| cfg_we | input | 1 | Priority table write strobe |
| cfg_id | input | IDX_W | ID whose priority is written |
| cfg_prio | input | PRIO_W | Priority value to store |
| reg_rd | input | 1 | Register read strobe (select 0 = acknowledge) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 acknowledge, 1 end-of-interrupt, 2 deactivate, 3 mask, 4 control |
| reg_wdata | input | DATA_W | Write data: an ID, a mask value or control bits |
| reg_rdata | output | DATA_W | Read data; for select 0 the acknowledged ID, or 1023 |
| irq_out | output | 1 | An interrupt is eligible to be taken |
| run_prio | output | PRIO_W | Current running priority |

## Verification
The properties assume that `reg_rd` and `reg_wr` are never high in the same cycle. Under that assumption an acknowledge and an end-of-interrupt can never meet on the stack or on the active bits. Every stimulus task drives at most one of the two strobes. The random phase draws priorities from a few coarse levels, so that ties and same-level preemption attempts occur often. Most end-of-interrupt IDs are taken from currently active interrupts, and some are unimplemented or invalid IDs, so that both the drop path and the ignore path are exercised.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

    localparam int ID_W        = 14;
    localparam int SOFT_LAST   = 15;
    localparam int PERIPH_LAST = 1019;
    localparam int EXT_FIRST   = 8192;

    localparam logic [ID_W-1:0] SPURIOUS_ID = 14'd1023;

    typedef enum logic [2:0] {
        SEL_ACK   = 3'd0,
        SEL_EOI   = 3'd1,
        SEL_DEACT = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_CTRL  = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        CLS_SOFT,
        CLS_PERIPH,
        CLS_RESERVED,
        CLS_EXTENDED
    } id_class_e;

    // bit 1: group enable, bit 0: split end-of-interrupt
    typedef struct packed {
        logic grp_en;
        logic eoi_split;
    } ctrl_t;

    function automatic id_class_e id_class(input logic [ID_W-1:0] id);
        if (int'(id) <= SOFT_LAST)        return CLS_SOFT;
        else if (int'(id) <= PERIPH_LAST) return CLS_PERIPH;
        else if (int'(id) < EXT_FIRST)    return CLS_RESERVED;
        else                              return CLS_EXTENDED;
    endfunction

    // True when the ID names an interrupt this instance implements
    function automatic logic id_implemented(input logic [ID_W-1:0] id, input int n_irq);
        id_class_e c;
        c = id_class(id);
        return ((c == CLS_SOFT) || (c == CLS_PERIPH)) && (int'(id) < n_irq);
    endfunction

endpackage

// File: rtl/cpuif_irq_state.sv
module cpuif_irq_state #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               ack_fire,
    input  logic [IDX_W-1:0]   ack_idx,
    input  logic               deact_fire,
    input  logic [IDX_W-1:0]   deact_idx,
    output logic [NUM_IRQ-1:0] pend_q,
    output logic [NUM_IRQ-1:0] act_q,
    output logic [PRIO_W-1:0]  prio_q [NUM_IRQ]
);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        logic              pend_r;
        logic              act_r;
        logic [PRIO_W-1:0] prio_r;
        logic              hit_ack;
        logic              hit_deact;
        logic              hit_cfg;

        assign hit_ack   = ack_fire   && (ack_idx   == IDX_W'(g));
        assign hit_deact = deact_fire && (deact_idx == IDX_W'(g));
        assign hit_cfg   = cfg_we     && (cfg_idx   == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_r <= 1'b0;
                act_r  <= 1'b0;
                prio_r <= '1;
            end else begin
                // a request arriving with the claim re-arms the pending bit
                pend_r <= (pend_r && !hit_ack) || irq_req[g];
                if (hit_ack)
                    act_r <= 1'b1;
                else if (hit_deact)
                    act_r <= 1'b0;
                if (hit_cfg)
                    prio_r <= cfg_prio;
            end
        end

        assign pend_q[g] = pend_r;
        assign act_q[g]  = act_r;
        assign prio_q[g] = prio_r;
    end

endmodule

// File: rtl/cpuif_select.sv
module cpuif_select #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic               allow,
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] act,
    input  logic [PRIO_W-1:0]  prio [NUM_IRQ],
    input  logic [PRIO_W-1:0]  mask,
    input  logic [PRIO_W-1:0]  run_prio,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);

    logic [NUM_IRQ-1:0] elig;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
        assign elig[g] = allow && pend[g] && !act[g]
                       && (prio[g] < mask) && (prio[g] < run_prio);
    end

    logic [PRIO_W-1:0] best;

    // strict compare keeps the lowest ID on equal priority
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!hit || (prio[i] < best))) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                best = prio[i];
            end
        end
    end

endmodule

// File: rtl/cpuif_prio_stack.sv
module cpuif_prio_stack #(
    parameter int DEPTH  = 4,
    parameter int PRIO_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [PRIO_W-1:0] top_prio,
    output logic              full,
    output logic              empty
);

    logic [CNT_W-1:0]  cnt_q;
    logic [PRIO_W-1:0] slot [DEPTH];
    logic              push_ok;
    logic              pop_ok;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && !full && !pop_ok;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (pop_ok)
            cnt_q <= cnt_q - 1'b1;
        else if (push_ok)
            cnt_q <= cnt_q + 1'b1;
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [PRIO_W-1:0] val_r;
        always_ff @(posedge clk) begin
            if (rst)
                val_r <= '1;
            else if (push_ok && (cnt_q == CNT_W'(s)))
                val_r <= push_prio;
        end
        assign slot[s] = val_r;
    end

    always_comb begin
        top_prio = '1;
        for (int s = 0; s < DEPTH; s++) begin
            if (cnt_q == CNT_W'(s + 1))
                top_prio = slot[s];
        end
    end

endmodule

// File: rtl/cpuif_split_eoi.sv
module cpuif_split_eoi
    import cpuif_pkg::*;
#(
    parameter int NUM_IRQ     = 32,
    parameter int PRIO_W      = 8,
    parameter int STACK_DEPTH = 4,
    parameter int DATA_W      = 16,
    localparam int IDX_W      = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_id,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [2:0]         reg_sel,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_out,
    output logic [PRIO_W-1:0]  run_prio
);

    reg_sel_e          sel;
    ctrl_t             ctrl_q;
    logic [PRIO_W-1:0] mask_q;

    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] act_q;
    logic [PRIO_W-1:0]  prio_q [NUM_IRQ];

    logic               pick_hit;
    logic [IDX_W-1:0]   pick_idx;
    logic               stk_full;
    logic               stk_empty;

    logic [ID_W-1:0]    wr_id;
    logic               wr_ok;
    logic [IDX_W-1:0]   wr_idx;
    logic               ack_fire;
    logic               eoi_wr;
    logic               dir_wr;
    logic               deact_fire;
    logic [ID_W-1:0]    ack_id;

    logic               grp_en_w;
    logic               split_w;

    assign sel      = reg_sel_e'(reg_sel);
    assign grp_en_w = ctrl_q.grp_en;
    assign split_w  = ctrl_q.eoi_split;

    // ---------------- programmable registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_MASK: mask_q <= reg_wdata[PRIO_W-1:0];
                SEL_CTRL: ctrl_q <= ctrl_t'(reg_wdata[1:0]);
                default:  ;
            endcase
        end
    end

    // ---------------- write decode ----------------
    assign wr_id  = reg_wdata[ID_W-1:0];
    assign wr_ok  = ((reg_wdata >> ID_W) == '0) && id_implemented(wr_id, NUM_IRQ);
    assign wr_idx = wr_id[IDX_W-1:0];

    assign ack_fire   = reg_rd && (sel == SEL_ACK) && pick_hit;
    assign eoi_wr     = reg_wr && (sel == SEL_EOI) && wr_ok;
    assign dir_wr     = reg_wr && (sel == SEL_DEACT) && wr_ok && ctrl_q.eoi_split;
    assign deact_fire = (eoi_wr && !ctrl_q.eoi_split) || dir_wr;

    // ---------------- sub-blocks ----------------
    cpuif_irq_state #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W)
    ) u_state (
        .clk        (clk),
        .rst        (rst),
        .irq_req    (irq_req),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_id),
        .cfg_prio   (cfg_prio),
        .ack_fire   (ack_fire),
        .ack_idx    (pick_idx),
        .deact_fire (deact_fire),
        .deact_idx  (wr_idx),
        .pend_q     (pend_q),
        .act_q      (act_q),
        .prio_q     (prio_q)
    );

    cpuif_select #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W)
    ) u_select (
        .allow    (ctrl_q.grp_en && !stk_full),
        .pend     (pend_q),
        .act      (act_q),
        .prio     (prio_q),
        .mask     (mask_q),
        .run_prio (run_prio),
        .hit      (pick_hit),
        .idx      (pick_idx)
    );

    cpuif_prio_stack #(
        .DEPTH  (STACK_DEPTH),
        .PRIO_W (PRIO_W)
    ) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (ack_fire),
        .push_prio (prio_q[pick_idx]),
        .pop       (eoi_wr),
        .top_prio  (run_prio),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    // ---------------- outputs ----------------
    assign irq_out = pick_hit;
    assign ack_id  = pick_hit ? ID_W'(pick_idx) : SPURIOUS_ID;

    always_comb begin
        case (sel)
            SEL_ACK:  reg_rdata = DATA_W'(ack_id);
            SEL_MASK: reg_rdata = DATA_W'(mask_q);
            SEL_CTRL: reg_rdata = DATA_W'(ctrl_q);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cpuif_checker.sv
module cpuif_checker #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_rd,
    input logic               reg_wr,
    input logic [2:0]         reg_sel,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               irq_out,
    input logic [PRIO_W-1:0]  run_prio,
    input logic               grp_en,
    input logic               eoi_split,
    input logic               stk_empty,
    input logic [NUM_IRQ-1:0] act_q
);

    localparam logic [DATA_W-1:0] SPUR = DATA_W'(1023);

    logic ack_rd;
    logic eoi_w;
    logic dir_w;
    logic id_impl;

    assign ack_rd  = reg_rd && (reg_sel == 3'd0);
    assign eoi_w   = reg_wr && (reg_sel == 3'd1);
    assign dir_w   = reg_wr && (reg_sel == 3'd2);
    assign id_impl = reg_wdata < DATA_W'(NUM_IRQ);

    AST_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !grp_en |-> !irq_out);                                            // R2

    AST_CLAIM_DEEPENS: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && reg_rdata != SPUR) |=> (run_prio < $past(run_prio)));  // R4

    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && reg_rdata == SPUR) |=> ($stable(run_prio) && act_q == $past(act_q))); // R5

    AST_DROP_RELAXES: assert property (@(posedge clk) disable iff (rst)
        (eoi_w && id_impl && !stk_empty) |=> (run_prio > $past(run_prio))); // R7

    AST_SPLIT_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (eoi_w && eoi_split) |=> (act_q == $past(act_q)));                // R8

    AST_DEACT_NEEDS_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (dir_w && !eoi_split) |=> (act_q == $past(act_q)));               // R10

    AST_BAD_ID_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        ((eoi_w || dir_w) && !id_impl) |=> ($stable(run_prio) && act_q == $past(act_q))); // R11

endmodule

bind cpuif_split_eoi cpuif_checker #(
    .NUM_IRQ (NUM_IRQ),
    .PRIO_W  (PRIO_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .run_prio  (run_prio),
    .grp_en    (grp_en_w),
    .eoi_split (split_w),
    .stk_empty (stk_empty),
    .act_q     (act_q)
);

// File: tb/sim_cpuif_split_eoi.sv
module sim_cpuif_split_eoi;

    localparam int N     = 32;
    localparam int PW    = 8;
    localparam int DEPTH = 4;
    localparam int DW    = 16;

    localparam logic [2:0] S_ACK = 3'd0, S_EOI = 3'd1, S_DIR = 3'd2, S_MASK = 3'd3, S_CTRL = 3'd4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_req = '0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_id = '0;
    logic [PW-1:0] cfg_prio = '0;
    logic          reg_rd = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_out;
    logic [PW-1:0] run_prio;

    int n_tests = 0;
    int n_fail  = 0;
    int last_rd = 0;

    always #5 clk = ~clk;

    cpuif_split_eoi #(.NUM_IRQ(N), .PRIO_W(PW), .STACK_DEPTH(DEPTH), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .cfg_we(cfg_we), .cfg_id(cfg_id),
        .cfg_prio(cfg_prio), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out), .run_prio(run_prio)
    );

    // ---------------- reference model ----------------
    bit        m_pend [N];
    bit        m_act  [N];
    logic [7:0] m_prio [N];
    logic [7:0] m_stk  [DEPTH];
    int        m_depth;
    bit        m_split, m_grp;
    logic [7:0] m_pmr;

    function automatic void m_reset();
        for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_act[i] = 0; m_prio[i] = 8'hFF; end
        m_depth = 0; m_split = 0; m_grp = 0; m_pmr = 8'h00;
    endfunction

    function automatic logic [7:0] m_run();
        return (m_depth == 0) ? 8'hFF : m_stk[m_depth-1];
    endfunction

    function automatic int m_pick();
        int best = -1;
        if (!m_grp || m_depth >= DEPTH) return -1;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && !m_act[i] && m_prio[i] < m_pmr && m_prio[i] < m_run())
                if (best < 0 || m_prio[i] < m_prio[best]) best = i;
        return best;
    endfunction

    task automatic check(input bit ok, input string rq, input string what, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, got, exp);
        end
    endtask

    // one clock: drive at negedge, compare, update model, advance
    task automatic step(input bit rd, input bit wr, input logic [2:0] sel, input int wd,
                        input logic [N-1:0] req, input bit cw, input int cid, input int cp);
        int pick;
        int exp_rd;
        int id;
        reg_rd = rd; reg_wr = wr; reg_sel = sel; reg_wdata = DW'(wd);
        irq_req = req; cfg_we = cw; cfg_id = 5'(cid); cfg_prio = 8'(cp);
        #1;
        pick = m_pick();
        check(irq_out === (pick >= 0), "R3", "irq_out", int'(irq_out), int'(pick >= 0));
        check(run_prio === m_run(), "R6", "run_prio", int'(run_prio), int'(m_run()));
        if (rd) begin
            case (sel)
                S_ACK:   exp_rd = (pick >= 0) ? pick : 1023;
                S_MASK:  exp_rd = int'(m_pmr);
                S_CTRL:  exp_rd = int'({m_grp, m_split});
                default: exp_rd = 0;
            endcase
            check(reg_rdata === DW'(exp_rd), "R4", "read data", int'(reg_rdata), exp_rd);
            last_rd = int'(reg_rdata);
        end
        // model update
        id = wd;
        if (rd && sel == S_ACK && pick >= 0) begin
            m_pend[pick] = 0; m_act[pick] = 1;
            m_stk[m_depth] = m_prio[pick]; m_depth++;
        end
        if (wr && sel == S_EOI && id < N) begin
            if (m_depth > 0) m_depth--;
            if (!m_split) m_act[id] = 0;
        end
        if (wr && sel == S_DIR && m_split && id < N) m_act[id] = 0;
        if (wr && sel == S_MASK) m_pmr = 8'(wd);
        if (wr && sel == S_CTRL) begin m_split = wd[0]; m_grp = wd[1]; end
        for (int i = 0; i < N; i++) if (req[i]) m_pend[i] = 1;
        if (cw) m_prio[cid] = 8'(cp);
        @(posedge clk);
        @(negedge clk);
        reg_rd = 0; reg_wr = 0; irq_req = '0; cfg_we = 0;
    endtask

    task automatic idle();                           step(0, 0, S_ACK, 0, '0, 0, 0, 0);   endtask
    task automatic ack();                            step(1, 0, S_ACK, 0, '0, 0, 0, 0);   endtask
    task automatic wreg(input logic [2:0] s, input int d); step(0, 1, s, d, '0, 0, 0, 0);  endtask
    task automatic raise(input int id);              step(0, 0, S_ACK, 0, N'(1) << id, 0, 0, 0); endtask
    task automatic setp(input int id, input int p);  step(0, 0, S_ACK, 0, '0, 1, id, p);  endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_reset();
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        do_reset();

        // R1 reset state
        check(irq_out === 1'b0, "R1", "irq_out after reset", int'(irq_out), 0);
        check(run_prio === 8'hFF, "R1", "run_prio after reset", int'(run_prio), 255);
        ack();
        check(last_rd == 1023, "R1", "ack after reset", last_rd, 1023);
        step(1, 0, S_CTRL, 0, '0, 0, 0, 0);
        check(last_rd == 0, "R1", "ctrl after reset", last_rd, 0);

        // R2 group enable gates signalling
        setp(5, 8'h20); wreg(S_MASK, 8'hF0); raise(5);
        check(irq_out === 1'b0, "R2", "irq_out with group off", int'(irq_out), 0);
        ack();
        check(last_rd == 1023, "R2", "ack with group off", last_rd, 1023);
        wreg(S_CTRL, 2);
        check(irq_out === 1'b1, "R2", "irq_out with group on", int'(irq_out), 1);

        // R3 mask is a strict compare
        wreg(S_MASK, 8'h20);
        check(irq_out === 1'b0, "R3", "prio equal to mask", int'(irq_out), 0);
        wreg(S_MASK, 8'h21);
        check(irq_out === 1'b1, "R3", "prio below mask", int'(irq_out), 1);
        wreg(S_MASK, 8'hF0);

        // R4 tie goes to lowest ID; R6 same level does not preempt
        setp(20, 8'h10); setp(7, 8'h10);
        step(0, 0, S_ACK, 0, (N'(1) << 20) | (N'(1) << 7), 0, 0, 0);
        ack();
        check(last_rd == 7, "R4", "tie winner", last_rd, 7);
        check(run_prio === 8'h10, "R4", "pushed prio", int'(run_prio), 16);
        check(irq_out === 1'b0, "R6", "same level blocked", int'(irq_out), 0);

        // R8 split mode: drop only
        wreg(S_CTRL, 3);
        wreg(S_EOI, 7);
        check(run_prio === 8'hFF, "R8", "drop in split mode", int'(run_prio), 255);
        ack();
        check(last_rd == 20, "R8", "same level taken after drop", last_rd, 20);
        raise(7);
        wreg(S_EOI, 20);
        ack();
        check(last_rd == 5, "R8", "active irq skipped", last_rd, 5);
        wreg(S_EOI, 5);
        check(irq_out === 1'b0, "R8", "dropped irq not resignalled", int'(irq_out), 0);

        // R9 deactivate re-enables
        wreg(S_DIR, 7);
        check(irq_out === 1'b1, "R9", "signalled after deactivate", int'(irq_out), 1);
        ack();
        check(last_rd == 7, "R9", "retaken after deactivate", last_rd, 7);
        wreg(S_EOI, 7); wreg(S_DIR, 7); wreg(S_DIR, 20); wreg(S_DIR, 5);

        // R10 deactivate ignored when inactive or not in split mode
        wreg(S_DIR, 9);
        check(run_prio === 8'hFF, "R10", "inactive deactivate", int'(run_prio), 255);
        setp(9, 8'h30); raise(9); ack();
        wreg(S_EOI, 9);
        wreg(S_CTRL, 2);
        wreg(S_DIR, 9);
        raise(9);
        check(irq_out === 1'b0, "R10", "deactivate ignored in mode 0", int'(irq_out), 0);

        // R7 combined drop and deactivate
        wreg(S_EOI, 9);
        check(irq_out === 1'b1, "R7", "mode 0 eoi deactivates", int'(irq_out), 1);
        ack();
        check(run_prio === 8'h30, "R7", "claim prio", int'(run_prio), 48);
        wreg(S_EOI, 9);
        check(run_prio === 8'hFF, "R7", "mode 0 drop", int'(run_prio), 255);
        raise(9); ack();
        check(last_rd == 9, "R7", "retaken after mode 0 eoi", last_rd, 9);
        wreg(S_EOI, 9);

        // R11 unimplemented IDs ignored
        setp(3, 8'h40); raise(3); ack();
        wreg(S_EOI, 1020);
        check(run_prio === 8'h40, "R11", "eoi reserved id", int'(run_prio), 64);
        wreg(S_EOI, 40);
        check(run_prio === 8'h40, "R11", "eoi unimplemented id", int'(run_prio), 64);
        wreg(S_EOI, 8192);
        check(run_prio === 8'h40, "R11", "eoi extended id", int'(run_prio), 64);
        wreg(S_EOI, 3);

        // R12 full stack blocks; R5 spurious changes nothing
        setp(10, 8'h40); setp(11, 8'h30); setp(12, 8'h20); setp(13, 8'h10); setp(14, 8'h08);
        for (int k = 10; k < 14; k++) begin raise(k); ack(); end
        raise(14);
        check(irq_out === 1'b0, "R12", "full stack blocks", int'(irq_out), 0);
        ack();
        check(last_rd == 1023, "R12", "ack on full stack", last_rd, 1023);
        check(run_prio === 8'h10, "R5", "spurious keeps prio", int'(run_prio), 16);
        wreg(S_EOI, 13);
        check(irq_out === 1'b1, "R12", "drop reopens", int'(irq_out), 1);
        ack();
        check(last_rd == 14, "R12", "claim after drop", last_rd, 14);
        wreg(S_EOI, 14); wreg(S_EOI, 12); wreg(S_EOI, 11); wreg(S_EOI, 10);

        // constrained random phase against the model
        do_reset();
        wreg(S_MASK, 8'hF0);
        wreg(S_CTRL, 2);
        for (int c = 0; c < N; c++) setp(c, int'(($urandom % 8) * 16));
        for (int t = 0; t < 4000; t++) begin
            int op;
            int id;
            int start;
            logic [N-1:0] rq;
            bit cw;
            op = int'($urandom % 16);
            rq = N'($urandom & $urandom & $urandom & $urandom);
            cw = ($urandom % 10) == 0;
            id = -1;
            if (op >= 5 && op <= 9) begin
                start = int'($urandom % N);
                if (($urandom % 10) < 8)
                    for (int j = 0; j < N; j++)
                        if (id < 0 && m_act[(start + j) % N]) id = (start + j) % N;
                if (id < 0) begin
                    case ($urandom % 3)
                        0: id = 1020;
                        1: id = 8192;
                        default: id = int'($urandom % 40);
                    endcase
                end
            end
            if (op <= 4)
                step(1, 0, S_ACK, 0, rq, cw, int'($urandom % N), int'(($urandom % 8) * 16));
            else if (op <= 7)
                step(0, 1, S_EOI, id, rq, cw, int'($urandom % N), int'(($urandom % 8) * 16));
            else if (op <= 9)
                step(0, 1, S_DIR, id, rq, 0, 0, 0);
            else if (op == 10)
                step(0, 1, S_MASK, (($urandom % 4) == 0) ? int'($urandom % 256) : 8'hF0, rq, 0, 0, 0);
            else if (op == 11)
                step(0, 1, S_CTRL, (($urandom % 8) == 0) ? int'($urandom % 2) : int'(2 | ($urandom % 2)), rq, 0, 0, 0);
            else if (op == 12)
                step(1, 0, (($urandom % 2) == 0) ? S_MASK : S_CTRL, 0, rq, 0, 0, 0);
            else
                step(0, 0, S_ACK, 0, rq, cw, int'($urandom % N), int'(($urandom % 8) * 16));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule